// File: doc/BRIEF.md
# DMA Error Interrupt and Fault Address Capture

This block gathers bus error events from three places inside a DMA controller: the master-side DMA engine, the slave-side DMA protocol checker and the command engine. Each source has its own sticky status bit. The status bits are gated by matching enable bits, and the gated bits are combined into one level-sensitive interrupt line.

The two sources that drive the master-side bus also report the address of the transfer that failed. Both write it into a single shared fault-address register. The slave-side checker reports no address.

Software reaches the block through a simple register port. A write strobe, a 12-bit word offset and write data are sampled on the clock. Read data is a combinational decode of the current offset. The status register clears through write-one-to-clear, the enable register is read/write, and the fault-address register is read-only.

Top module: `dma_err_intc`

## Requirements
- R1: After synchronous reset, the status register (offset 0x110), the enable register (offset 0x114) and the fault-address register (offset 0x140) all read 0, and `irq_o` is low.
- R2: A master-DMA error pulse sets status bit 0 on the next clock edge and loads `mdma_addr_i` into the fault-address register.
- R3: A slave-DMA error pulse sets status bit 1 and leaves the fault-address register unchanged.
- R4: A command-engine error pulse sets status bit 2 and loads `cmd_addr_i` into the fault-address register.
- R5: When master-DMA and command-engine errors arrive in the same cycle, the fault-address register takes `cmd_addr_i`.
- R6: A status bit is set whether or not its enable bit is set. A set status bit whose enable bit is clear does not raise `irq_o`.
- R7: `irq_o` is high exactly while at least one status bit and its enable bit (same bit position) are both 1.
- R8: Writing to offset 0x110 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R9: An error event in the same cycle as a write-one-to-clear of the same bit leaves that bit set.
- R10: Enable bits 2:0 at offset 0x114 are writable and read back. Bits above 2 read 0.
- R11: Writes to offset 0x140 are ignored, and reads from unmapped offsets return 0.
- R12: Status bits stay set after their error input returns low, until software clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mdma_err_i | input | 1 | Master-DMA bus error pulse |
| mdma_addr_i | input | ADDR_W | Address of the failing master-DMA transfer |
| sdma_err_i | input | 1 | Slave-DMA protocol error pulse |
| cmd_err_i | input | 1 | Command-engine bus error pulse |
| cmd_addr_i | input | ADDR_W | Address of the failing command-engine transfer |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from the offset |
| irq_o | output | 1 | Level-sensitive error interrupt |

## Verification
The bench targets the shared fault-address register under simultaneous master and command errors. A design with the wrong priority would report the master address. It also checks that a slave-only error leaves the register untouched; a careless design would overwrite it with garbage.

A clear that lands in the same cycle as a new event must not lose the event. The bench also writes zeros to the status register, which must not clear anything. Together these catch a design that treats the status register as plain read/write.

Masking is checked in both directions. Status must latch while the enable bit is clear, and the interrupt must follow only the enabled bits. Writes to the read-only address register must be ignored.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

    localparam int NUM_SRC = 3;
    localparam int REG_AW  = 12;

    localparam logic [REG_AW-1:0] OFS_STATUS  = 12'h110;
    localparam logic [REG_AW-1:0] OFS_ENABLE  = 12'h114;
    localparam logic [REG_AW-1:0] OFS_FLTADDR = 12'h140;

    // bit positions of the sources inside status and enable
    typedef enum int {
        SRC_MDMA = 0,
        SRC_SDMA = 1,
        SRC_CMD  = 2
    } err_src_e;

    // one field per source, mdma in bit 0
    typedef struct packed {
        logic cmd;
        logic sdma;
        logic mdma;
    } err_evt_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ENABLE,
        SEL_FLTADDR
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [REG_AW-1:0] ofs);
        case (ofs)
            OFS_STATUS:  return SEL_STATUS;
            OFS_ENABLE:  return SEL_ENABLE;
            OFS_FLTADDR: return SEL_FLTADDR;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dma_err_status.sv
module dma_err_status
    import dma_err_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);

    logic [N-1:0] bits_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                bits_q[i] <= 1'b1;      // a new event beats a clear
            end else if (clr_i[i]) begin
                bits_q[i] <= 1'b0;
            end
        end
    end

    assign status_o = bits_q;

endmodule

// File: rtl/dma_err_addr_cap.sv
module dma_err_addr_cap #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdma_vld_i,
    input  logic [ADDR_W-1:0] mdma_addr_i,
    input  logic              cmd_vld_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;
    logic              load;

    always_comb begin
        load   = cmd_vld_i | mdma_vld_i;
        addr_d = cmd_vld_i ? cmd_addr_i : mdma_addr_i;   // command engine wins
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/dma_err_regs.sv
module dma_err_regs
    import dma_err_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_i,
    input  logic [REG_AW-1:0]  ofs_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [ADDR_W-1:0]  fltaddr_i,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [NUM_SRC-1:0] enable_o,
    output logic [DATA_W-1:0]  rdata_o
);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] en_q;

    always_comb sel = decode_ofs(ofs_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_i && sel == SEL_ENABLE) begin
            en_q <= wdata_i[NUM_SRC-1:0];
        end
    end

    always_comb begin
        clr_o = '0;
        if (wr_i && sel == SEL_STATUS) begin
            clr_o = wdata_i[NUM_SRC-1:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_STATUS:  rdata_o = DATA_W'(status_i);
            SEL_ENABLE:  rdata_o = DATA_W'(en_q);
            SEL_FLTADDR: rdata_o = DATA_W'(fltaddr_i);
            default:     rdata_o = '0;
        endcase
    end

    assign enable_o = en_q;

endmodule

// File: rtl/dma_err_intc.sv
module dma_err_intc
    import dma_err_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdma_err_i,
    input  logic [ADDR_W-1:0] mdma_addr_i,
    input  logic              sdma_err_i,
    input  logic              cmd_err_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    err_evt_t           evt;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] clr_vec;
    logic [ADDR_W-1:0]  flt_addr;
    logic               irq_q;

    always_comb begin
        evt.mdma = mdma_err_i;
        evt.sdma = sdma_err_i;
        evt.cmd  = cmd_err_i;
    end

    dma_err_status #(.N(NUM_SRC)) u_status (
        .clk      (clk),
        .rst      (rst),
        .set_i    (evt),
        .clr_i    (clr_vec),
        .status_o (status_q)
    );

    dma_err_addr_cap #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .mdma_vld_i  (evt.mdma),
        .mdma_addr_i (mdma_addr_i),
        .cmd_vld_i   (evt.cmd),
        .cmd_addr_i  (cmd_addr_i),
        .addr_o      (flt_addr)
    );

    dma_err_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (reg_wr_i),
        .ofs_i     (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .status_i  (status_q),
        .fltaddr_i (flt_addr),
        .clr_o     (clr_vec),
        .enable_o  (enable_q),
        .rdata_o   (reg_rdata_o)
    );

    always_comb irq_q = |(status_q & enable_q);
    assign irq_o = irq_q;

endmodule

// File: rtl/dma_err_intc_chk.sv
module dma_err_intc_chk
    import dma_err_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               mdma_err,
    input logic               sdma_err,
    input logic               cmd_err,
    input logic [ADDR_W-1:0]  cmd_addr,
    input logic               reg_wr,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [NUM_SRC-1:0] status,
    input logic [ADDR_W-1:0]  flt_addr,
    input logic               irq
);

    p_mdma_set_r2: assert property (@(posedge clk) disable iff (rst)
        mdma_err |=> status[SRC_MDMA]);

    p_sdma_noaddr_r3: assert property (@(posedge clk) disable iff (rst)
        (sdma_err && !mdma_err && !cmd_err) |=> $stable(flt_addr));

    p_cmd_addr_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> (status[SRC_CMD] && flt_addr == $past(cmd_addr)));

    p_no_status_no_irq_r6: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |-> !irq);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_STATUS && reg_wdata[SRC_SDMA] && !sdma_err)
        |=> !status[SRC_SDMA]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        sdma_err |=> status[SRC_SDMA]);

    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (status[SRC_CMD] && !(reg_wr && reg_addr == OFS_STATUS && reg_wdata[SRC_CMD]))
        |=> status[SRC_CMD]);

endmodule

bind dma_err_intc dma_err_intc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mdma_err  (mdma_err_i),
    .sdma_err  (sdma_err_i),
    .cmd_err   (cmd_err_i),
    .cmd_addr  (cmd_addr_i),
    .reg_wr    (reg_wr_i),
    .reg_addr  (reg_addr_i),
    .reg_wdata (reg_wdata_i),
    .status    (status_q),
    .flt_addr  (flt_addr),
    .irq       (irq_o)
);

// File: tb/tb_dma_err_intc.sv
module tb_dma_err_intc;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mdma_err = 1'b0;
    logic [ADDR_W-1:0] mdma_addr = '0;
    logic              sdma_err = 1'b0;
    logic              cmd_err = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              reg_wr = 1'b0;
    logic [11:0]       reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    dma_err_intc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk         (clk),
        .rst         (rst),
        .mdma_err_i  (mdma_err),
        .mdma_addr_i (mdma_addr),
        .sdma_err_i  (sdma_err),
        .cmd_err_i   (cmd_err),
        .cmd_addr_i  (cmd_addr),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    // monitor: compares at the falling edge, away from register updates
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_rd(input logic [11:0] ofs, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = ofs;
        sb_q.push_back('{is_irq: 1'b0, exp: exp, tag: tag});
        @(negedge clk); #1;
    endtask

    task automatic expect_irq(input bit exp, input string tag);
        @(posedge clk); #1;
        sb_q.push_back('{is_irq: 1'b1, exp: {31'b0, exp}, tag: tag});
        @(negedge clk); #1;
    endtask

    // one cycle of stimulus: events and an optional register write together
    task automatic drive(input bit m, input logic [31:0] ma, input bit s,
                         input bit c, input logic [31:0] ca,
                         input bit wr, input logic [11:0] ofs, input logic [31:0] wd);
        @(posedge clk); #1;
        mdma_err = m; mdma_addr = ma; sdma_err = s; cmd_err = c; cmd_addr = ca;
        reg_wr = wr; reg_addr = ofs; reg_wdata = wd;
        @(posedge clk); #1;
        mdma_err = 0; sdma_err = 0; cmd_err = 0; reg_wr = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_rd(12'h110, 32'h0, "R1 status");
        expect_rd(12'h114, 32'h0, "R1 enable");
        expect_rd(12'h140, 32'h0, "R1 fault addr");
        expect_irq(1'b0, "R1 irq");

        // R2 master error, R6 not enabled yet
        drive(1, 32'hA000_1000, 0, 0, 32'h0, 0, 12'h0, 32'h0);
        expect_rd(12'h110, 32'h1, "R2 status");
        expect_rd(12'h140, 32'hA000_1000, "R2 fault addr");
        expect_irq(1'b0, "R6 masked irq");

        // R3 slave error keeps address
        drive(0, 32'hDEAD_BEEF, 1, 0, 32'h0, 0, 12'h0, 32'h0);
        expect_rd(12'h110, 32'h3, "R3 status");
        expect_rd(12'h140, 32'hA000_1000, "R3 fault addr");

        // R4 command error
        drive(0, 32'h0, 0, 1, 32'hC000_0040, 0, 12'h0, 32'h0);
        expect_rd(12'h110, 32'h7, "R4 status");
        expect_rd(12'h140, 32'hC000_0040, "R4 fault addr");

        // R12 sticky after idle cycles
        repeat (5) @(posedge clk);
        expect_rd(12'h110, 32'h7, "R12 sticky");

        // R10 enable register, upper bits read 0; R7 irq rises
        drive(0, 0, 0, 0, 0, 1, 12'h114, 32'hFFFF_FFFF);
        expect_rd(12'h114, 32'h7, "R10 enable readback");
        expect_irq(1'b1, "R7 irq high");

        // R8 write of zero clears nothing, write of bit 1 clears only it
        drive(0, 0, 0, 0, 0, 1, 12'h110, 32'h0);
        expect_rd(12'h110, 32'h7, "R8 zero write");
        drive(0, 0, 0, 0, 0, 1, 12'h110, 32'h2);
        expect_rd(12'h110, 32'h5, "R8 w1c bit1");

        // R11 read-only fault addr, unmapped read
        drive(0, 0, 0, 0, 0, 1, 12'h140, 32'h1234_5678);
        expect_rd(12'h140, 32'hC000_0040, "R11 ro fault addr");
        expect_rd(12'h200, 32'h0, "R11 unmapped");

        // R6/R7 masking by enable
        drive(0, 0, 0, 0, 0, 1, 12'h114, 32'h2);
        expect_irq(1'b0, "R6 only slave enabled");
        drive(0, 0, 1, 0, 0, 0, 12'h0, 32'h0);
        expect_irq(1'b1, "R7 slave irq");
        drive(0, 0, 0, 0, 0, 1, 12'h110, 32'h7);
        expect_rd(12'h110, 32'h0, "R8 clear all");
        expect_irq(1'b0, "R7 irq drops");

        // R5 simultaneous capture
        drive(1, 32'h1111_0000, 0, 1, 32'h2222_0000, 0, 12'h0, 32'h0);
        expect_rd(12'h140, 32'h2222_0000, "R5 cmd wins");
        expect_rd(12'h110, 32'h5, "R5 status");

        // R9 set beats clear in the same cycle
        drive(0, 0, 1, 0, 0, 1, 12'h110, 32'h2);
        expect_rd(12'h110, 32'h7, "R9 set wins");

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule